// File: doc/BRIEF.md
# Auxiliary Event Counter Bank

A bank of auxiliary 64-bit event counters. Each implemented counter adds one in every cycle where its event line is high and the shared count enable is set. It wraps silently from all ones to zero. Software reaches the bank through a pair of 32-bit data halves and a 4-bit counter index. A write joins the two halves into one 64-bit value and loads either the counter or that counter's 64-bit virtual offset register.

A read carries the privilege level of the requester, from 0 to 3, where 3 is the highest level. The level decides what the read returns: the raw physical count, the count minus the offset (modulo 2^64), or zero. Two offset-enable controls belong to the two upper control levels. A read-as-zero control masks the count for every level below the highest. The read result is registered and appears one cycle after the request. An index at or above the number of implemented counters is refused and flagged.

Top module: `aux_evcnt_bank`

## Requirements
- R1: Counter k adds 1 at a clock edge where event_i[k] and count_en_i are both 1. With either one at 0, and no write to k, the counter keeps its value.
- R2: While rst_ni is low, every counter and every offset register is zero, and rd_valid_o, undef_o, rd_lo_o and rd_hi_o are 0.
- R3: wr_i with a valid index loads counter idx_i with {wr_hi_i, wr_lo_i}: wr_hi_i is bits 63:32 and wr_lo_i is bits 31:0. off_wr_i loads that counter's offset register in the same way.
- R4: rd_i with a valid index sets rd_valid_o in the next cycle. In that cycle rd_hi_o holds bits 63:32 and rd_lo_o holds bits 31:0 of the result, computed from the counter value before that clock edge. In every other cycle rd_valid_o, rd_lo_o and rd_hi_o are 0.
- R5: A read at level 0 or 1, with raz_i at 0 and both voff_en_a_i and voff_en_b_i at 1, returns the count minus the offset register, modulo 2^64. With either enable at 0 it returns the physical count.
- R6: A read at level 2 with raz_i at 0 returns the physical count with no offset applied, whatever the offset enables are.
- R7: A read at level 0, 1 or 2 with raz_i at 1 returns 64 zero bits.
- R8: A read at level 3 ignores raz_i and both offset enables, and returns the physical count.
- R9: An access (rd_i, wr_i or off_wr_i) whose idx_i is at or above NUM_CNT sets undef_o in the next cycle and leaves rd_valid_o at 0. It changes no counter and no offset register.
- R10: When a write and an increment reach the same counter at the same edge, the counter takes the written value.
- R11: A counter at all ones that increments becomes zero. No overflow indication exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| event_i | input | 16 | Per-counter event lines |
| count_en_i | input | 1 | Shared count enable |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Counter write request |
| off_wr_i | input | 1 | Offset register write request |
| idx_i | input | 4 | Counter index |
| lvl_i | input | 2 | Privilege level of the read |
| wr_lo_i | input | 32 | Write data, bits 31:0 |
| wr_hi_i | input | 32 | Write data, bits 63:32 |
| voff_en_a_i | input | 1 | Offset enable from the first upper control level |
| voff_en_b_i | input | 1 | Offset enable from the second upper control level |
| raz_i | input | 1 | Read-as-zero for levels below the highest |
| rd_valid_o | output | 1 | Read result valid |
| rd_lo_o | output | 32 | Read result, bits 31:0 |
| rd_hi_o | output | 32 | Read result, bits 63:32 |
| undef_o | output | 1 | Refused access (index out of range) |

## Verification
The assertions assume that at most one of rd_i, wr_i and off_wr_i is high in any cycle. The top-level onehot check states this assumption. The bench drives each access as a single-cycle pulse and never overlaps them. Event lines and the count enable may change freely and are driven on the falling edge, so each rising edge sees stable values. The bench instance sets NUM_CNT to 12, so indices 12 to 15 reach the refused-access path.

// File: rtl/aux_evcnt_pkg.sv
package aux_evcnt_pkg;
  localparam int unsigned MAX_CNT = 16;
  localparam int unsigned IDX_W   = $clog2(MAX_CNT);
  localparam int unsigned LVL_W   = 2;
  localparam logic [LVL_W-1:0] TOP_LVL = 2'd3;
  localparam logic [LVL_W-1:0] VIRT_MAX_LVL = 2'd1;

  typedef enum logic [1:0] {
    VIEW_PHYS = 2'd0,
    VIEW_VIRT = 2'd1,
    VIEW_ZERO = 2'd2
  } view_e;

  function automatic view_e pick_view(input logic [LVL_W-1:0] lvl, input logic raz,
                                      input logic en_a, input logic en_b);
    if (lvl == TOP_LVL)                               return VIEW_PHYS;
    else if (raz)                                     return VIEW_ZERO;
    else if (lvl <= VIRT_MAX_LVL && en_a && en_b)     return VIEW_VIRT;
    else                                              return VIEW_PHYS;
  endfunction
endpackage

// File: rtl/aux_cnt_cell.sv
module aux_cnt_cell #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_i,
  input  logic             off_wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] off_o
);
  logic [CNT_W-1:0] cnt_q, off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_i) begin
      cnt_q <= wr_data_i;
    end else if (inc_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       off_q <= '0;
    else if (off_wr_i) off_q <= wr_data_i;
  end

  assign cnt_o = cnt_q;
  assign off_o = off_q;

  // R10
  wr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wr_data_i));

  // R11
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i && (&cnt_q)) |=> cnt_q == '0);

  // R1
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_i) |=> $stable(cnt_q));

  // R3
  off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !off_wr_i |=> $stable(off_q));
endmodule

// File: rtl/aux_idx_dec.sv
module aux_idx_dec
  import aux_evcnt_pkg::*;
#(
  parameter int unsigned NUM_CNT = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic               off_wr_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic               acc_ok_o,
  output logic [NUM_CNT-1:0] wr_sel_o,
  output logic [NUM_CNT-1:0] off_sel_o,
  output logic               undef_o
);
  logic any_acc, undef_q;

  assign any_acc  = rd_i | wr_i | off_wr_i;
  assign acc_ok_o = ({1'b0, idx_i} < (IDX_W+1)'(NUM_CNT));

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_sel
    logic hit;
    assign hit          = acc_ok_o && (idx_i == IDX_W'(k));
    assign wr_sel_o[k]  = hit && wr_i;
    assign off_sel_o[k] = hit && off_wr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) undef_q <= 1'b0;
    else         undef_q <= any_acc && !acc_ok_o;
  end

  assign undef_o = undef_q;

  // R3
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_sel_o, off_sel_o}));
endmodule

// File: rtl/aux_rd_view.sv
module aux_rd_view
  import aux_evcnt_pkg::*;
#(
  parameter int unsigned NUM_CNT = 16,
  parameter int unsigned CNT_W   = 64,
  localparam int unsigned HALF_W = CNT_W / 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rd_i,
  input  logic                           acc_ok_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [LVL_W-1:0]               lvl_i,
  input  logic                           raz_i,
  input  logic                           voff_en_a_i,
  input  logic                           voff_en_b_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]  off_i,
  output logic                           rd_valid_o,
  output logic [HALF_W-1:0]              rd_lo_o,
  output logic [HALF_W-1:0]              rd_hi_o
);
  logic [CNT_W-1:0] phys_sel, off_sel, view_d, data_q;
  logic             valid_q, rd_ok;
  view_e            mode;

  always_comb begin
    phys_sel = '0;
    off_sel  = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (idx_i == IDX_W'(k)) begin
        phys_sel = cnt_i[k];
        off_sel  = off_i[k];
      end
    end
  end

  assign mode  = pick_view(lvl_i, raz_i, voff_en_a_i, voff_en_b_i);
  assign rd_ok = rd_i && acc_ok_i;

  always_comb begin
    unique case (mode)
      VIEW_VIRT: view_d = phys_sel - off_sel;
      VIEW_ZERO: view_d = '0;
      default:   view_d = phys_sel;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_ok;
      data_q  <= rd_ok ? view_d : '0;
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_lo_o    = data_q[HALF_W-1:0];
  assign rd_hi_o    = data_q[CNT_W-1:HALF_W];

  // R8
  top_phys_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && lvl_i == TOP_LVL) |=> {rd_hi_o, rd_lo_o} == $past(phys_sel));

  // R7
  raz_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && raz_i && lvl_i != TOP_LVL) |=> {rd_hi_o, rd_lo_o} == '0);

  // R6
  lvl2_phys_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && !raz_i && lvl_i == 2'd2) |=> {rd_hi_o, rd_lo_o} == $past(phys_sel));

  // R4
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> (rd_lo_o == '0 && rd_hi_o == '0));
endmodule

// File: rtl/aux_evcnt_bank.sv
module aux_evcnt_bank
  import aux_evcnt_pkg::*;
#(
  parameter int unsigned NUM_CNT = 16,
  parameter int unsigned CNT_W   = 64,
  localparam int unsigned HALF_W = CNT_W / 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MAX_CNT-1:0] event_i,
  input  logic               count_en_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic               off_wr_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [LVL_W-1:0]   lvl_i,
  input  logic [HALF_W-1:0]  wr_lo_i,
  input  logic [HALF_W-1:0]  wr_hi_i,
  input  logic               voff_en_a_i,
  input  logic               voff_en_b_i,
  input  logic               raz_i,
  output logic               rd_valid_o,
  output logic [HALF_W-1:0]  rd_lo_o,
  output logic [HALF_W-1:0]  rd_hi_o,
  output logic               undef_o
);
  logic                          acc_ok;
  logic [NUM_CNT-1:0]            wr_sel, off_sel;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec, off_vec;
  logic [CNT_W-1:0]              wr_data;

  assign wr_data = {wr_hi_i, wr_lo_i};

  aux_idx_dec #(.NUM_CNT(NUM_CNT)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .off_wr_i  (off_wr_i),
    .idx_i     (idx_i),
    .acc_ok_o  (acc_ok),
    .wr_sel_o  (wr_sel),
    .off_sel_o (off_sel),
    .undef_o   (undef_o)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cell
    aux_cnt_cell #(.CNT_W(CNT_W)) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (event_i[k] && count_en_i),
      .wr_i      (wr_sel[k]),
      .off_wr_i  (off_sel[k]),
      .wr_data_i (wr_data),
      .cnt_o     (cnt_vec[k]),
      .off_o     (off_vec[k])
    );
  end

  aux_rd_view #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_view (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (rd_i),
    .acc_ok_i    (acc_ok),
    .idx_i       (idx_i),
    .lvl_i       (lvl_i),
    .raz_i       (raz_i),
    .voff_en_a_i (voff_en_a_i),
    .voff_en_b_i (voff_en_b_i),
    .cnt_i       (cnt_vec),
    .off_i       (off_vec),
    .rd_valid_o  (rd_valid_o),
    .rd_lo_o     (rd_lo_o),
    .rd_hi_o     (rd_hi_o)
  );

  // input assumption: one access per cycle
  one_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_i, wr_i, off_wr_i}));

  // R9
  undef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i || off_wr_i) && !acc_ok) |=> (undef_o && !rd_valid_o));

  // R4
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && acc_ok) |=> (rd_valid_o && !undef_o));
endmodule

// File: tb/aux_evcnt_bank_bench.sv
module aux_evcnt_bank_bench;
  localparam int NB = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ev = '0;
  logic        cen = 1'b0, rd = 1'b0, wr = 1'b0, owr = 1'b0;
  logic [3:0]  idx = '0;
  logic [1:0]  lvl = '0;
  logic [31:0] lo = '0, hi = '0;
  logic        ena = 1'b0, enb = 1'b0, raz = 1'b0;
  logic        rd_valid, undef;
  logic [31:0] rd_lo, rd_hi;

  int checks = 0, fails = 0;
  bit started = 0, done = 0;
  string cur_tag = "R2", exp_tag = "R2";

  logic [63:0] m_cnt [16];
  logic [63:0] m_off [16];
  logic        exp_valid, exp_undef;
  logic [63:0] exp_data;

  always #2 clk = ~clk;

  aux_evcnt_bank #(.NUM_CNT(NB)) u_aux_evcnt_bank (
    .clk_i(clk), .rst_ni(rst_n), .event_i(ev), .count_en_i(cen),
    .rd_i(rd), .wr_i(wr), .off_wr_i(owr), .idx_i(idx), .lvl_i(lvl),
    .wr_lo_i(lo), .wr_hi_i(hi), .voff_en_a_i(ena), .voff_en_b_i(enb),
    .raz_i(raz), .rd_valid_o(rd_valid), .rd_lo_o(rd_lo), .rd_hi_o(rd_hi),
    .undef_o(undef)
  );

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) begin m_cnt[k] = '0; m_off[k] = '0; end
      exp_valid = 0; exp_undef = 0; exp_data = '0; exp_tag = "R2";
    end else begin
      logic ok;
      ok = (int'(idx) < NB);
      exp_tag   = cur_tag;
      exp_undef = (rd || wr || owr) && !ok;
      exp_valid = rd && ok;
      exp_data  = '0;
      if (rd && ok) begin
        if (lvl == 2'd3)                 exp_data = m_cnt[idx];
        else if (raz)                    exp_data = '0;
        else if (lvl < 2'd2 && ena && enb) exp_data = m_cnt[idx] - m_off[idx];
        else                             exp_data = m_cnt[idx];
      end
      for (int k = 0; k < NB; k++) begin
        if (wr && ok && int'(idx) == k) m_cnt[k] = {hi, lo};
        else if (ev[k] && cen)          m_cnt[k] = m_cnt[k] + 64'd1;
        if (owr && ok && int'(idx) == k) m_off[k] = {hi, lo};
      end
    end
    started = 1;
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (rd_valid !== exp_valid || undef !== exp_undef || {rd_hi, rd_lo} !== exp_data) begin
        fails++;
        $display("FAIL %s: valid=%0b undef=%0b data=%h expected valid=%0b undef=%0b data=%h",
                 exp_tag, rd_valid, undef, {rd_hi, rd_lo}, exp_valid, exp_undef, exp_data);
      end
    end
  end

  task automatic access(input bit r, input bit w, input bit o, input int i,
                        input int l, input logic [63:0] d, input string tag);
    @(negedge clk);
    rd = r; wr = w; owr = o; idx = 4'(i); lvl = 2'(l);
    hi = d[63:32]; lo = d[31:0]; cur_tag = tag;
    @(negedge clk);
    rd = 0; wr = 0; owr = 0;
  endtask

  task automatic rd_at(input int i, input int l, input string tag);
    access(1, 0, 0, i, l, 64'd0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    cur_tag = tag;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: all counters zero after reset
    for (int k = 0; k < NB; k++) rd_at(k, 3, "R2");
    // R3 / R4: joined write, halves on readback
    access(0, 1, 0, 3, 0, 64'h12345678_9abcdef0, "R3");
    rd_at(3, 3, "R4");
    // R1: counting under enable
    @(negedge clk);
    cen = 1; cur_tag = "R1";
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      ev = 16'(c * 16'h0515 + 1);
    end
    @(negedge clk);
    cen = 0; ev = 16'hffff;
    idle(5, "R1");
    ev = 16'h0000;
    for (int k = 0; k < NB; k++) rd_at(k, 3, "R1");
    // R5: virtual offset
    access(0, 0, 1, 3, 0, 64'h0000_0000_0000_0010, "R3");
    ena = 1; enb = 1;
    rd_at(3, 0, "R5");
    rd_at(3, 1, "R5");
    enb = 0;
    rd_at(3, 0, "R5");
    enb = 1; ena = 0;
    rd_at(3, 1, "R5");
    ena = 1;
    access(0, 0, 1, 5, 0, 64'hffff_0000_0000_0001, "R3");
    rd_at(5, 0, "R5");
    // R6: level 2 sees physical count
    rd_at(3, 2, "R6");
    rd_at(5, 2, "R6");
    // R7 / R8: read-as-zero
    raz = 1;
    rd_at(3, 0, "R7");
    rd_at(3, 1, "R7");
    rd_at(5, 2, "R7");
    rd_at(3, 3, "R8");
    rd_at(5, 3, "R8");
    raz = 0;
    rd_at(5, 3, "R8");
    ena = 0; enb = 0;
    // R11: wrap
    access(0, 1, 0, 7, 0, 64'hffff_ffff_ffff_ffff, "R11");
    @(negedge clk);
    cen = 1; ev = 16'h0080; cur_tag = "R11";
    @(negedge clk);
    ev = 16'h0000; cen = 0;
    rd_at(7, 3, "R11");
    // R10: write beats increment
    @(negedge clk);
    cen = 1; ev = 16'h0004;
    rd = 0; wr = 1; idx = 4'd2; hi = 32'hcafe0000; lo = 32'h00000055; cur_tag = "R10";
    @(negedge clk);
    wr = 0; ev = 16'h0000; cen = 0;
    rd_at(2, 3, "R10");
    // R9: out-of-range indices
    rd_at(13, 3, "R9");
    access(0, 1, 0, 12, 0, 64'h1, "R9");
    access(0, 0, 1, 15, 0, 64'h2, "R9");
    rd_at(15, 0, "R9");
    for (int k = 0; k < NB; k++) rd_at(k, 3, "R9");
    idle(2, "R1");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule